// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Engine

This block sits behind a serial receiver and moves the bytes it delivers into memory buffers owned by a host. The buffers are described by a ring of up to eight eight-byte descriptors held in a table at a programmable base address. For each descriptor the engine reads a control word, checks that the host has handed the descriptor over, loads the buffer pointer, and then writes incoming bytes one at a time through a 16-bit memory port with byte strobes.

A buffer is closed when it is full, when the receiver reports an error, or when a hunt command arrives. On close, the engine writes the byte count and a status word that returns ownership to the host. It then moves to the next descriptor, or back to the first one after a descriptor flagged as last. If the interrupt-enable bit of that descriptor is set and the global mask is clear, the engine pulses an interrupt. Bytes that arrive while the current descriptor still belongs to the host are dropped, and the next buffer to close reports an overrun.

Receive events pass through a short in-order queue. Bytes, error marks and hunt commands are therefore handled in the order they arrived, even while the engine is busy on the memory port.

Top module: `rxring_engine`

## Requirements
- R1: While `rst_n` is low and right after reset, `irq`, `cfg_err`, `mem_req` and `mem_we` are 0, and the ring index is 0.
- R2: Descriptor i sits at `base_addr + 8*i`. Offset 0 holds the control word, offset 2 the byte count, offset 4 the upper pointer half (only its bits 7:0 are used) and offset 6 the lower pointer half. The buffer pointer is 24 bits.
- R3: Byte k of a buffer is written to byte address `ptr + k`. At an even address `mem_be` = 2'b10 and the byte is in `mem_wdata[15:8]`. At an odd address `mem_be` = 2'b01 and the byte is in `mem_wdata[7:0]`. The other byte of the word is left unchanged.
- R4: When the byte count of the open buffer reaches `max_len`, the buffer is closed with a count equal to `max_len`.
- R5: A strobe with `rx_valid` and `rx_err` both high carries no data. It closes the open buffer with the count of bytes received so far and sets control bit 0 (carrier/error).
- R6: A `hunt_cmd` pulse closes the open buffer with the count so far and control bit 0 clear. If it arrives in the same cycle as `rx_valid`, the byte in that cycle is lost.
- R7: An error strobe or hunt pulse that arrives when the current buffer has received no byte is discarded, and memory is not written.
- R8: The control word written on close has bit 15 (owned-by-engine) cleared. Bits 14:12 (external, last-in-ring, interrupt-enable) are kept as read. Bits 11:2 are zero. Bit 1 is the overrun flag and bit 0 is the error flag.
- R9: After the descriptor whose bit 13 is set has been closed, the next descriptor used is index 0.
- R10: After index 7 is closed without bit 13 set, the engine returns to index 0 and sets `cfg_err`, which stays set until reset.
- R11: If the current descriptor has bit 15 clear, each arriving byte is dropped without any write, and the engine stays on that descriptor. The next buffer closed then has bit 1 set.
- R12: `irq` is high for exactly one cycle per close, only when the closed descriptor has bit 12 set and `irq_mask` is low during the status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_addr | input | 24 | Byte address of descriptor 0 |
| max_len | input | 16 | Buffer size in bytes (at least 1) |
| irq_mask | input | 1 | Global interrupt mask, 1 suppresses `irq` |
| rx_valid | input | 1 | Receive strobe |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | With `rx_valid`, marks a receive error instead of a byte |
| hunt_cmd | input | 1 | Enter-hunt command pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_be | output | 2 | Byte strobes, bit 1 = even byte |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| irq | output | 1 | Buffer-closed interrupt pulse |
| cfg_err | output | 1 | Sticky flag: ring had no last-entry marker in eight entries |

## Verification
The hardest case to reach is the dropped-byte path of R11. It needs a descriptor still owned by the host while traffic arrives, followed by a late hand-over and a close, and the overrun must then be seen on the later close rather than on the refused one. The bench arms the ring with descriptor 0 cleared and sends bytes. It checks that the buffer and the neighbouring descriptor are untouched, then rewrites descriptor 0 in its memory model and closes a short buffer with a hunt. The forced wrap of R10 is reached by arming eight entries of one byte each with no last marker, so that each byte closes one entry.

// File: rtl/rxring_pkg.sv
// Package: shared types and control-word bit positions for the receive ring engine.
// Assumes descriptors are eight bytes long and memory words are 16 bits wide.
package rxring_pkg;

    typedef enum logic [1:0] {
        TK_BYTE = 2'd0,
        TK_ERR  = 2'd1,
        TK_HUNT = 2'd2
    } tok_kind_e;

    typedef struct packed {
        tok_kind_e  kind;
        logic [7:0] data;
    } rx_tok_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ST,
        S_RD_PH,
        S_RD_PL,
        S_CAP_PL,
        S_WR_DAT,
        S_WR_LEN,
        S_WR_ST
    } eng_state_e;

    localparam int unsigned CW_OWN  = 15;
    localparam int unsigned CW_EXT  = 14;
    localparam int unsigned CW_LAST = 13;
    localparam int unsigned CW_IEN  = 12;
    localparam int unsigned CW_OVR  = 1;
    localparam int unsigned CW_ERR  = 0;

    localparam int unsigned OFS_LEN = 2;
    localparam int unsigned OFS_PHI = 4;
    localparam int unsigned OFS_PLO = 6;

endpackage

// File: rtl/rxring_fifo.sv
// Module: small in-order queue for receive tokens.
// A push into a full queue is dropped and reported on ovf for one cycle.
// Assumes DEPTH is a power of two.
module rxring_fifo #(
    parameter int unsigned WIDTH = 10,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             ovf
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [PW:0]      fill;
    logic             full, do_push, do_pop;

    assign full    = (fill == (PW+1)'(DEPTH));
    assign empty   = (fill == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slots[rd_ptr];

    // Store pushed tokens.
    always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr] <= din;
    end

    // Pointer, fill level and overflow bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            ovf    <= 1'b0;
        end else begin
            ovf <= push && full;
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/rxring_index.sv
// Module: ring position counter.
// Steps to the next descriptor on adv. Returns to 0 after a descriptor marked
// last, or after the final slot with a sticky configuration error.
module rxring_index #(
    parameter int unsigned NDESC = 8,
    localparam int unsigned IW   = (NDESC > 1) ? $clog2(NDESC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          last_flag,
    output logic [IW-1:0] idx,
    output logic          cfg_err
);
    localparam logic [IW-1:0] LAST_IDX = IW'(NDESC - 1);

    // Advance the ring position and latch the missing-marker error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            cfg_err <= 1'b0;
        end else if (adv) begin
            if (last_flag) begin
                idx <= '0;
            end else if (idx == LAST_IDX) begin
                idx     <= '0;
                cfg_err <= 1'b1;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxring_ctrl.sv
// Module: descriptor fetch, buffer fill and close sequencer.
// Consumes tokens from the queue and drives the memory port.
// Assumes read data returns one cycle after a read request and writes
// complete in the cycle they are issued.
module rxring_ctrl
    import rxring_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned NDESC  = 8,
    localparam int unsigned IW    = (NDESC > 1) ? $clog2(NDESC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [15:0]       max_len,
    input  logic              irq_mask,
    input  logic              tok_valid,
    input  rx_tok_t           tok,
    output logic              tok_pop,
    input  logic              ovf_drop,
    input  logic [IW-1:0]     idx,
    output logic              adv,
    output logic              last_flag,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    output logic              irq
);
    eng_state_e        state, nxt;
    logic [15:0]       ctl_word;
    logic [7:0]        ptr_hi;
    logic [23:0]       ptr;
    logic [15:0]       cnt;
    logic [7:0]        byte_q;
    logic              have_desc, ovr_pend, err_flag;
    logic [ADDR_W-1:0] desc_addr, byte_addr;
    logic [15:0]       close_word;
    logic              drop_now;

    assign desc_addr  = base_addr + ADDR_W'({idx, 3'b000});
    assign byte_addr  = ADDR_W'(ptr) + ADDR_W'(cnt);
    assign close_word = {1'b0, ctl_word[CW_EXT], ctl_word[CW_LAST], ctl_word[CW_IEN],
                         10'b0, ovr_pend, err_flag};
    assign last_flag  = ctl_word[CW_LAST];
    assign adv        = (state == S_WR_ST);
    assign drop_now   = (state == S_RD_PH) && !mem_rdata[CW_OWN];

    // Next state, token pop and memory port drive.
    always_comb begin
        nxt       = state;
        tok_pop   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_be    = 2'b11;
        mem_addr  = desc_addr;
        mem_wdata = 16'h0000;
        case (state)
            S_IDLE: begin
                if (tok_valid) begin
                    if (tok.kind != TK_BYTE && cnt == 16'd0) begin
                        tok_pop = 1'b1;
                    end else if (!have_desc) begin
                        nxt = S_RD_ST;
                    end else begin
                        tok_pop = 1'b1;
                        nxt     = (tok.kind == TK_BYTE) ? S_WR_DAT : S_WR_LEN;
                    end
                end
            end
            S_RD_ST: begin
                mem_req = 1'b1;
                nxt     = S_RD_PH;
            end
            S_RD_PH: begin
                if (mem_rdata[CW_OWN]) begin
                    mem_req  = 1'b1;
                    mem_addr = desc_addr + ADDR_W'(OFS_PHI);
                    nxt      = S_RD_PL;
                end else begin
                    tok_pop = 1'b1;
                    nxt     = S_IDLE;
                end
            end
            S_RD_PL: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + ADDR_W'(OFS_PLO);
                nxt      = S_CAP_PL;
            end
            S_CAP_PL: begin
                nxt = S_IDLE;
            end
            S_WR_DAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = byte_addr;
                mem_be    = byte_addr[0] ? 2'b01 : 2'b10;
                mem_wdata = {byte_q, byte_q};
                nxt       = (cnt + 16'd1 == max_len) ? S_WR_LEN : S_IDLE;
            end
            S_WR_LEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + ADDR_W'(OFS_LEN);
                mem_wdata = cnt;
                nxt       = S_WR_ST;
            end
            S_WR_ST: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = close_word;
                nxt       = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Descriptor fields, fill count and close flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_word  <= '0;
            ptr_hi    <= '0;
            ptr       <= '0;
            cnt       <= '0;
            byte_q    <= '0;
            have_desc <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (tok_pop && have_desc && !(tok.kind != TK_BYTE && cnt == 16'd0)) begin
                        byte_q   <= tok.data;
                        err_flag <= (tok.kind == TK_ERR);
                    end
                end
                S_RD_PH:  ctl_word <= mem_rdata;
                S_RD_PL:  ptr_hi   <= mem_rdata[7:0];
                S_CAP_PL: begin
                    ptr       <= {ptr_hi, mem_rdata};
                    have_desc <= 1'b1;
                end
                S_WR_DAT: cnt <= cnt + 16'd1;
                S_WR_ST: begin
                    cnt       <= '0;
                    have_desc <= 1'b0;
                    err_flag  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Overrun flag: set by any dropped byte, cleared by the close that reports it.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ovr_pend <= 1'b0;
        else if (ovf_drop || drop_now)  ovr_pend <= 1'b1;
        else if (state == S_WR_ST)      ovr_pend <= 1'b0;
    end

    // Interrupt pulse on close.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (state == S_WR_ST) && ctl_word[CW_IEN] && !irq_mask;
    end
endmodule

// File: rtl/rxring_engine.sv
// Module: top of the receive buffer descriptor ring engine.
// Packs receive strobes into ordered tokens, queues them and hands them to the
// sequencer, which walks the descriptor ring. A hunt pulse takes priority over
// a byte presented in the same cycle.
module rxring_engine
    import rxring_pkg::*;
#(
    parameter int unsigned ADDR_W  = 24,
    parameter int unsigned NDESC   = 8,
    parameter int unsigned Q_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [15:0]       max_len,
    input  logic              irq_mask,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_err,
    input  logic              hunt_cmd,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    output logic              irq,
    output logic              cfg_err
);
    localparam int unsigned IW    = (NDESC > 1) ? $clog2(NDESC) : 1;
    localparam int unsigned TOK_W = $bits(rx_tok_t);

    rx_tok_t       in_tok, head_tok;
    logic          q_empty, q_pop, q_ovf;
    logic [IW-1:0] idx;
    logic          adv, last_flag;

    // Build the token for this cycle's receive event.
    always_comb begin
        in_tok.data = rx_data;
        if (hunt_cmd)    in_tok.kind = TK_HUNT;
        else if (rx_err) in_tok.kind = TK_ERR;
        else             in_tok.kind = TK_BYTE;
    end

    rxring_fifo #(.WIDTH(TOK_W), .DEPTH(Q_DEPTH)) u_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_valid || hunt_cmd),
        .din   (in_tok),
        .pop   (q_pop),
        .head  (head_tok),
        .empty (q_empty),
        .ovf   (q_ovf)
    );

    rxring_index #(.NDESC(NDESC)) u_idx (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .last_flag (last_flag),
        .idx       (idx),
        .cfg_err   (cfg_err)
    );

    rxring_ctrl #(.ADDR_W(ADDR_W), .NDESC(NDESC)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_addr (base_addr),
        .max_len   (max_len),
        .irq_mask  (irq_mask),
        .tok_valid (!q_empty),
        .tok       (head_tok),
        .tok_pop   (q_pop),
        .ovf_drop  (q_ovf),
        .idx       (idx),
        .adv       (adv),
        .last_flag (last_flag),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_be    (mem_be),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .irq       (irq)
    );
endmodule

// File: rtl/rxring_engine_chk.sv
// Checker: port-level properties of the receive ring engine, bound to the top.
module rxring_engine_chk #(
    parameter int unsigned ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_mask,
    input logic              mem_req,
    input logic              mem_we,
    input logic [1:0]        mem_be,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [15:0]       mem_wdata,
    input logic              irq,
    input logic              cfg_err
);
    logic st_wr;
    assign st_wr = mem_req && mem_we && (mem_be == 2'b11) && (mem_addr[2:0] == 3'b000);

    a_r1_write_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    a_r3_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != 2'b11) |-> (mem_be == (mem_addr[0] ? 2'b01 : 2'b10)));

    a_r8_close_word: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |-> (!mem_wdata[15] && mem_wdata[11:2] == 10'd0));

    a_r12_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r12_irq_after_close: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(st_wr && mem_wdata[12] && !irq_mask));

    a_r10_cfg_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_err) |-> cfg_err);
endmodule

bind rxring_engine rxring_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_mask  (irq_mask),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .irq       (irq),
    .cfg_err   (cfg_err)
);

// File: tb/tb_rxring_engine.sv
module tb_rxring_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] base_addr = 24'h0;
    logic [15:0] max_len = 16'd16;
    logic        irq_mask = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h0;
    logic        rx_err = 1'b0;
    logic        hunt_cmd = 1'b0;
    logic        mem_req, mem_we, irq, cfg_err;
    logic [1:0]  mem_be;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'h0;

    logic [15:0] mem [0:2047];
    int total = 0;
    int bad = 0;
    int irq_cnt = 0;

    always #2.5 clk = ~clk;

    rxring_engine dut (.*);

    // Memory model: one-cycle read latency, byte-strobed writes.
    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:1]];
        if (mem_req && mem_we) begin
            if (mem_be[1]) mem[mem_addr[11:1]][15:8] <= mem_wdata[15:8];
            if (mem_be[0]) mem[mem_addr[11:1]][7:0]  <= mem_wdata[7:0];
        end
    end

    always @(negedge clk) if (irq) irq_cnt++;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] wd(input int byte_addr);
        return mem[byte_addr >> 1];
    endfunction

    task automatic set_desc(input int i, input logic [15:0] ctl, input int ptr);
        mem[i*4]     = ctl;
        mem[i*4 + 1] = 16'hBEEF;
        mem[i*4 + 2] = 16'(ptr >> 16);
        mem[i*4 + 3] = 16'(ptr);
    endtask

    task automatic restart(input logic [15:0] mlen);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 2048; i++) mem[i] = 16'h0;
        max_len = mlen;
        irq_mask = 1'b0;
        repeat (3) @(negedge clk);
        irq_cnt = 0;
    endtask

    task automatic go();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [7:0] d, input logic e, input logic h);
        @(negedge clk);
        rx_valid = !h;
        rx_data  = d;
        rx_err   = e;
        hunt_cmd = h;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_err   = 1'b0;
        hunt_cmd = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic settle();
        repeat (30) @(negedge clk);
    endtask

    task automatic t_reset();
        restart(16'd4);
        chk("R1 irq in reset", 16'(irq), 16'h0);
        chk("R1 cfg_err in reset", 16'(cfg_err), 16'h0);
        chk("R1 mem_req in reset", 16'(mem_req), 16'h0);
        go();
        @(negedge clk);
        chk("R1 mem_we after reset", 16'(mem_we), 16'h0);
        chk("R1 irq after reset", 16'(irq), 16'h0);
    endtask

    task automatic t_full_odd();
        restart(16'd4);
        set_desc(0, 16'h9000, 24'h000101);
        mem[24'h100 >> 1] = 16'hEEEE;
        mem[24'h102 >> 1] = 16'hEEEE;
        mem[24'h104 >> 1] = 16'hEEEE;
        go();
        send(8'hA1, 0, 0); send(8'hA2, 0, 0); send(8'hA3, 0, 0); send(8'hA4, 0, 0);
        settle();
        chk("R3 odd first byte lane", wd(24'h100), 16'hEEA1);
        chk("R3 middle word", wd(24'h102), 16'hA2A3);
        chk("R3 last byte lane", wd(24'h104), 16'hA4EE);
        chk("R4 full count", wd(2), 16'd4);
        chk("R8 close word", wd(0), 16'h1000);
        chk("R12 one pulse", 16'(irq_cnt), 16'd1);
    endtask

    task automatic t_err();
        restart(16'd16);
        set_desc(0, 16'h8000, 24'h000200);
        go();
        send(8'h11, 0, 0); send(8'h22, 0, 0); send(8'h99, 1, 0);
        settle();
        chk("R5 count at error", wd(2), 16'd2);
        chk("R5 error bit set", wd(0), 16'h0001);
        chk("R5 data kept", wd(24'h200), 16'h1122);
        chk("R12 no irq when enable clear", 16'(irq_cnt), 16'd0);
    endtask

    task automatic t_hunt();
        restart(16'd16);
        set_desc(0, 16'hD000, 24'h000200);
        go();
        send(8'h11, 0, 0); send(8'h22, 0, 0); send(8'h33, 0, 0); send(8'h00, 0, 1);
        settle();
        chk("R6 count at hunt", wd(2), 16'd3);
        chk("R6 R8 close word keeps X and I", wd(0), 16'h5000);
        chk("R6 data", wd(24'h202), 16'h3300);
        chk("R12 irq on hunt close", 16'(irq_cnt), 16'd1);
    endtask

    task automatic t_ignore();
        restart(16'd16);
        set_desc(0, 16'h8000, 24'h000200);
        go();
        send(8'h00, 0, 1); send(8'h55, 1, 0);
        settle();
        chk("R7 ctl untouched", wd(0), 16'h8000);
        chk("R7 count untouched", wd(2), 16'hBEEF);
        send(8'h77, 0, 0); send(8'h00, 0, 1);
        settle();
        chk("R7 later buffer count", wd(2), 16'd1);
        chk("R7 later close word", wd(0), 16'h0000);
    endtask

    task automatic t_wrap();
        restart(16'd1);
        set_desc(0, 16'h8000, 24'h000200);
        set_desc(1, 16'hA000, 24'h000220);
        set_desc(2, 16'h8000, 24'h000240);
        go();
        send(8'h01, 0, 0); send(8'h02, 0, 0);
        settle();
        chk("R9 last entry close word", wd(8), 16'h2000);
        mem[0] = 16'h8000;
        mem[1] = 16'hBEEF;
        send(8'h03, 0, 0);
        settle();
        chk("R9 entry 0 reused", wd(2), 16'd1);
        chk("R9 entry 0 data", wd(24'h200), 16'h0300);
        chk("R9 entry 2 untouched", wd(18), 16'hBEEF);
        chk("R2 entry 1 data at own pointer", wd(24'h220), 16'h0200);
    endtask

    task automatic t_force_wrap();
        restart(16'd1);
        for (int i = 0; i < 9; i++) set_desc(i, 16'h8000, 24'h000200 + i*32);
        go();
        for (int i = 0; i < 7; i++) send(8'(i + 1), 0, 0);
        settle();
        chk("R10 no flag before slot 7", 16'(cfg_err), 16'h0);
        send(8'h08, 0, 0);
        settle();
        chk("R10 flag after slot 7", 16'(cfg_err), 16'h1);
        mem[0] = 16'h8000;
        mem[1] = 16'hBEEF;
        send(8'h09, 0, 0);
        settle();
        chk("R10 back at entry 0", wd(2), 16'd1);
        chk("R10 entry 8 untouched", wd(66), 16'hBEEF);
        chk("R10 flag stays", 16'(cfg_err), 16'h1);
    endtask

    task automatic t_not_ready();
        restart(16'd16);
        set_desc(0, 16'h0000, 24'h000200);
        set_desc(1, 16'h8000, 24'h000220);
        mem[24'h200 >> 1] = 16'h5555;
        go();
        send(8'hC1, 0, 0); send(8'hC2, 0, 0);
        settle();
        chk("R11 buffer untouched", wd(24'h200), 16'h5555);
        chk("R11 entry 1 untouched", wd(10), 16'hBEEF);
        mem[0] = 16'h8000;
        send(8'h07, 0, 0); send(8'h08, 0, 0); send(8'h00, 0, 1);
        settle();
        chk("R11 count after hand-over", wd(2), 16'd2);
        chk("R11 overrun reported", wd(0), 16'h0002);
        chk("R11 data after hand-over", wd(24'h200), 16'h0708);
    endtask

    task automatic t_mask();
        restart(16'd1);
        set_desc(0, 16'h9000, 24'h000200);
        set_desc(1, 16'hB000, 24'h000220);
        go();
        irq_mask = 1'b1;
        send(8'h01, 0, 0);
        settle();
        chk("R12 masked no irq", 16'(irq_cnt), 16'd0);
        chk("R12 masked close done", wd(0), 16'h1000);
        irq_mask = 1'b0;
        send(8'h02, 0, 0);
        settle();
        chk("R12 unmasked single pulse", 16'(irq_cnt), 16'd1);
    endtask

    initial begin
        t_reset();
        t_full_odd();
        t_err();
        t_hunt();
        t_ignore();
        t_wrap();
        t_force_wrap();
        t_not_ready();
        t_mask();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule